// File: doc/BRIEF.md
# Debug Abstract Command Sequencer

This block lives inside a RISC-V debug module. It runs abstract register-access commands and Program Buffer execution without any direct port into the core's register file. Instead, it pushes instruction words into the core's instruction prefetch path over a valid/ready handshake.

A GPR transfer becomes one CSR instruction that moves a value between the GPR and the debug data0 register, which the core sees as a debug CSR. That instruction is followed by an `ebreak`. Program Buffer execution sends the buffer words in order and then an implicit `ebreak`. A command finishes when the core pulses that it reached the `ebreak`. If the core pulses an exception, the sequence stops.

The block keeps the last accepted command. It re-issues that command when the host touches data0 or a Program Buffer word whose auto-execute enable is set. It keeps a sticky, write-1-to-clear error code. It also forwards resume requests to the core on a dedicated pulse; no `dret` instruction is used.

Top module: `dbg_abscmd_seq`

## Requirements
- R1: A transfer with write=0 from GPR n issues `csrrw x0, DATA0_CSR, xn`, encoded as {DATA0_CSR, n[4:0], 3'b001, 5'd0, 7'b1110011}.
- R2: A transfer with write=1 into GPR n issues `csrrs xn, DATA0_CSR, x0`, encoded as {DATA0_CSR, 5'd0, 3'b010, n[4:0], 7'b1110011}.
- R3: Every transfer instruction is followed by `ebreak` (32'h00100073). `busy` stays high until the cycle after `core_ebreak` pulses while the block waits.
- R4: Program Buffer execution issues words 0 to PB_WORDS-1 in order. Word i is `pbuf_words[32*i +: 32]`. An implicit `ebreak` follows the last word, and completion again waits for `core_ebreak`.
- R5: Command word fields are: type [31:24] (0 = register access), size [22:20] (2 = 32 bits), postexec [18], transfer [17], write [16] and regno [15:0] (GPR n is 0x1000+n). With transfer and postexec both set, the GPR transfer and its `ebreak` complete first, then the Program Buffer runs. With transfer clear, postexec alone runs the buffer, and a command with both clear does nothing.
- R6: When `auto_data0` is high, a `data0_access` pulse re-issues the last accepted command. When it is low, the pulse has no effect.
- R7: A `pbuf_access` pulse re-issues the last accepted command only if `auto_pbuf[pbuf_idx]` is set.
- R8: A `core_exception` pulse while busy stops the sequence (no further words and no `ebreak`), clears `busy` and records cmderr 3.
- R9: A command write or an auto trigger that arrives while busy is ignored and records cmderr 1. The running sequence is unaffected.
- R10: A command with type ≠ 0 is unsupported; this covers memory access. A transfer with size ≠ 2 or regno outside 0x1000..0x101F is also unsupported. An unsupported command records cmderr 2 and issues nothing.
- R11: `cmderr` is sticky, and each `cmderr_clr` bit clears the matching bit. While `cmderr` is nonzero, no command or auto trigger starts and no new code is recorded.
- R12: `resume_req` while idle gives a one-cycle `core_resume` pulse in the next cycle. While busy, `resume_req` is ignored.
- R13: While `instr_valid` is high and `instr_ready` is low, `instr_valid` and `instr_data` hold.
- R14: After reset, `busy`, `cmderr` and `instr_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_word | input | 32 | Command value written |
| data0_access | input | 1 | Host read or write of data0 |
| pbuf_access | input | 1 | Host read or write of a Program Buffer word |
| pbuf_idx | input | IDXW | Index of the Program Buffer word accessed |
| auto_data0 | input | 1 | Auto-execute on data0 access enable |
| auto_pbuf | input | PB_WORDS | Auto-execute enable for each Program Buffer word |
| pbuf_words | input | 32*PB_WORDS | Program Buffer contents, word 0 in the low bits |
| cmderr_clr | input | 3 | Write-1-to-clear strobe for cmderr bits |
| resume_req | input | 1 | Host request to resume the core |
| busy | output | 1 | A command sequence is in progress |
| cmderr | output | 3 | Sticky command error code |
| instr_valid | output | 1 | Injected instruction valid |
| instr_ready | input | 1 | Core accepts the injected instruction |
| instr_data | output | 32 | Injected instruction word |
| core_ebreak | input | 1 | Core reached the injected ebreak |
| core_except | input | 1 | Core took an exception on an injected instruction |
| core_resume | output | 1 | Resume pulse to the core |

## Verification
The bench builds the block with PB_WORDS=2 and the default DATA0_CSR. With two buffer words, the step from the last word into the implicit `ebreak` is reached in a few cycles. A single bit of `pbuf_idx` is then enough to show that an enabled word triggers and a disabled word does not. The short buffer also leaves room, within a compact run, to stall the core handshake in the middle of a buffer sequence and to land collisions, exceptions and resume requests there.

// File: rtl/dbg_abscmd_pkg.sv
package dbg_abscmd_pkg;

    localparam logic [6:0]  OPC_SYSTEM   = 7'b1110011;
    localparam logic [31:0] INSN_EBREAK  = 32'h0010_0073;
    localparam logic [7:0]  CMDTYPE_REG  = 8'h00;
    localparam logic [2:0]  SIZE_WORD    = 3'd2;
    localparam logic [10:0] GPR_REGNO_HI = 11'h080;  // regno[15:5] for 0x1000..0x101F

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_PBUF,
        ST_BRK,
        ST_WAIT
    } seq_state_e;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_BUSY   = 3'd1,
        ERR_UNSUP  = 3'd2,
        ERR_EXCEPT = 3'd3
    } cmderr_e;

    typedef struct packed {
        logic       transfer;
        logic       write;
        logic       postexec;
        logic [4:0] gpr;
    } acc_cmd_t;

    // Move GPR into the debug CSR: csrrw x0, csr, rs1
    function automatic logic [31:0] insn_gpr_to_csr(input logic [11:0] csr, input logic [4:0] rs1);
        return {csr, rs1, 3'b001, 5'd0, OPC_SYSTEM};
    endfunction

    // Move the debug CSR into GPR: csrrs rd, csr, x0
    function automatic logic [31:0] insn_csr_to_gpr(input logic [11:0] csr, input logic [4:0] rd);
        return {csr, 5'd0, 3'b010, rd, OPC_SYSTEM};
    endfunction

endpackage

// File: rtl/dbg_abscmd_decode.sv
module dbg_abscmd_decode
    import dbg_abscmd_pkg::*;
(
    input  logic [31:0] cmd_word,
    output acc_cmd_t    cmd,
    output logic        supported
);
    logic [7:0]  f_type;
    logic [2:0]  f_size;
    logic [15:0] f_regno;
    logic        unused_bits;

    assign f_type      = cmd_word[31:24];
    assign f_size      = cmd_word[22:20];
    assign f_regno     = cmd_word[15:0];
    assign unused_bits = ^{cmd_word[23], cmd_word[19]};

    always_comb begin
        cmd.postexec = cmd_word[18];
        cmd.transfer = cmd_word[17];
        cmd.write    = cmd_word[16];
        cmd.gpr      = f_regno[4:0];
    end

    always_comb begin
        supported = (f_type == CMDTYPE_REG);
        if (cmd.transfer) begin
            if (f_size != SIZE_WORD)               supported = 1'b0;
            if (f_regno[15:5] != GPR_REGNO_HI)     supported = 1'b0;
        end
    end
endmodule

// File: rtl/dbg_abscmd_dispatch.sv
module dbg_abscmd_dispatch
    import dbg_abscmd_pkg::*;
#(
    parameter int PB_WORDS = 4,
    localparam int IDXW    = (PB_WORDS > 1) ? $clog2(PB_WORDS) : 1
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_wr,
    input  acc_cmd_t            dec_cmd,
    input  logic                dec_ok,
    input  logic                data0_access,
    input  logic                auto_data0,
    input  logic                pbuf_access,
    input  logic [IDXW-1:0]     pbuf_idx,
    input  logic [PB_WORDS-1:0] auto_pbuf,
    input  logic [2:0]          cmderr_clr,
    input  logic                busy,
    input  logic                except_abort,
    output logic                start,
    output acc_cmd_t            start_cmd,
    output logic [2:0]          cmderr
);
    acc_cmd_t   last_q;
    logic [2:0] err_q;
    logic       auto_hit;
    logic       pb_hit;
    logic       set_err;
    cmderr_e    set_code;

    always_comb begin
        pb_hit = 1'b0;
        for (int i = 0; i < PB_WORDS; i++) begin
            if (pbuf_idx == IDXW'(i) && auto_pbuf[i]) pb_hit = 1'b1;
        end
    end

    assign auto_hit = (data0_access && auto_data0) || (pbuf_access && pb_hit);

    always_comb begin
        start     = 1'b0;
        start_cmd = last_q;
        set_err   = 1'b0;
        set_code  = ERR_NONE;
        if (err_q == 3'd0) begin
            if (except_abort) begin
                set_err  = 1'b1;
                set_code = ERR_EXCEPT;
            end else if (cmd_wr) begin
                if (busy) begin
                    set_err  = 1'b1;
                    set_code = ERR_BUSY;
                end else if (!dec_ok) begin
                    set_err  = 1'b1;
                    set_code = ERR_UNSUP;
                end else begin
                    start     = 1'b1;
                    start_cmd = dec_cmd;
                end
            end else if (auto_hit) begin
                if (busy) begin
                    set_err  = 1'b1;
                    set_code = ERR_BUSY;
                end else begin
                    start = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= 3'd0;
            last_q <= '0;
        end else begin
            if (set_err) err_q <= set_code;
            else         err_q <= err_q & ~cmderr_clr;
            if (start && cmd_wr) last_q <= dec_cmd;
        end
    end

    assign cmderr = err_q;

    // R11
    cmderr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q != 3'd0 && cmderr_clr == 3'd0) |=> $stable(err_q));

    // R11
    no_start_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q != 3'd0) |-> !start);

    // R9
    busy_collision_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr && err_q == 3'd0 && !except_abort) |=> (err_q == 3'd1));
endmodule

// File: rtl/dbg_abscmd_sequencer.sv
module dbg_abscmd_sequencer
    import dbg_abscmd_pkg::*;
#(
    parameter int          PB_WORDS  = 4,
    parameter logic [11:0] DATA0_CSR = 12'hbf0,
    localparam int         IDXW      = (PB_WORDS > 1) ? $clog2(PB_WORDS) : 1,
    localparam int         PBW       = 32 * PB_WORDS
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  acc_cmd_t       start_cmd,
    input  logic [PBW-1:0] pbuf_words,
    input  logic           resume_req,
    output logic           busy,
    output logic           except_abort,
    output logic           instr_valid,
    input  logic           instr_ready,
    output logic [31:0]    instr_data,
    input  logic           core_ebreak,
    input  logic           core_except,
    output logic           core_resume
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(PB_WORDS - 1);

    seq_state_e     state_q;
    acc_cmd_t       cur_q;
    logic [IDXW-1:0] pidx_q;
    logic           phase_pb_q;
    logic           resume_q;
    logic           accept;

    always_comb begin
        instr_valid = 1'b0;
        instr_data  = 32'd0;
        unique case (state_q)
            ST_XFER: begin
                instr_valid = 1'b1;
                instr_data  = cur_q.write ? insn_csr_to_gpr(DATA0_CSR, cur_q.gpr)
                                          : insn_gpr_to_csr(DATA0_CSR, cur_q.gpr);
            end
            ST_PBUF: begin
                instr_valid = 1'b1;
                instr_data  = pbuf_words[32*int'(pidx_q) +: 32];
            end
            ST_BRK: begin
                instr_valid = 1'b1;
                instr_data  = INSN_EBREAK;
            end
            default: ;
        endcase
    end

    assign accept       = instr_valid && instr_ready;
    assign busy         = (state_q != ST_IDLE);
    assign except_abort = busy && core_except;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cur_q      <= '0;
            pidx_q     <= '0;
            phase_pb_q <= 1'b0;
        end else if (except_abort) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cur_q      <= start_cmd;
                    pidx_q     <= '0;
                    phase_pb_q <= 1'b0;
                    if (start_cmd.transfer) begin
                        state_q <= ST_XFER;
                    end else if (start_cmd.postexec) begin
                        state_q    <= ST_PBUF;
                        phase_pb_q <= 1'b1;
                    end
                end
                ST_XFER: if (accept) state_q <= ST_BRK;
                ST_PBUF: if (accept) begin
                    if (pidx_q == LAST_IDX) state_q <= ST_BRK;
                    else                    pidx_q  <= pidx_q + 1'b1;
                end
                ST_BRK: if (accept) state_q <= ST_WAIT;
                ST_WAIT: if (core_ebreak) begin
                    if (cur_q.transfer && cur_q.postexec && !phase_pb_q) begin
                        state_q    <= ST_PBUF;
                        pidx_q     <= '0;
                        phase_pb_q <= 1'b1;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) resume_q <= 1'b0;
        else     resume_q <= resume_req && (state_q == ST_IDLE) && !start;
    end
    assign core_resume = resume_q;

    // R13
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !instr_ready && !core_except) |=> (instr_valid && $stable(instr_data)));

    // R3
    wait_for_ebreak_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !core_ebreak && !core_except) |=> busy);

    // R8
    except_stops_chk: assert property (@(posedge clk) disable iff (rst)
        except_abort |=> !instr_valid);

    // R12
    resume_idle_chk: assert property (@(posedge clk) disable iff (rst)
        core_resume |-> $past(!busy));

    // R4
    pidx_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PBUF) |-> (int'(pidx_q) < PB_WORDS));
endmodule

// File: rtl/dbg_abscmd_seq.sv
module dbg_abscmd_seq
    import dbg_abscmd_pkg::*;
#(
    parameter int          PB_WORDS  = 4,
    parameter logic [11:0] DATA0_CSR = 12'hbf0,
    localparam int         IDXW      = (PB_WORDS > 1) ? $clog2(PB_WORDS) : 1
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_wr,
    input  logic [31:0]            cmd_word,
    input  logic                   data0_access,
    input  logic                   pbuf_access,
    input  logic [IDXW-1:0]        pbuf_idx,
    input  logic                   auto_data0,
    input  logic [PB_WORDS-1:0]    auto_pbuf,
    input  logic [32*PB_WORDS-1:0] pbuf_words,
    input  logic [2:0]             cmderr_clr,
    input  logic                   resume_req,
    output logic                   busy,
    output logic [2:0]             cmderr,
    output logic                   instr_valid,
    input  logic                   instr_ready,
    output logic [31:0]            instr_data,
    input  logic                   core_ebreak,
    input  logic                   core_except,
    output logic                   core_resume
);
    acc_cmd_t dec_cmd;
    logic     dec_ok;
    logic     start;
    acc_cmd_t start_cmd;
    logic     except_abort;

    dbg_abscmd_decode u_decode (
        .cmd_word  (cmd_word),
        .cmd       (dec_cmd),
        .supported (dec_ok)
    );

    dbg_abscmd_dispatch #(.PB_WORDS(PB_WORDS)) u_dispatch (
        .clk          (clk),
        .rst          (rst),
        .cmd_wr       (cmd_wr),
        .dec_cmd      (dec_cmd),
        .dec_ok       (dec_ok),
        .data0_access (data0_access),
        .auto_data0   (auto_data0),
        .pbuf_access  (pbuf_access),
        .pbuf_idx     (pbuf_idx),
        .auto_pbuf    (auto_pbuf),
        .cmderr_clr   (cmderr_clr),
        .busy         (busy),
        .except_abort (except_abort),
        .start        (start),
        .start_cmd    (start_cmd),
        .cmderr       (cmderr)
    );

    dbg_abscmd_sequencer #(.PB_WORDS(PB_WORDS), .DATA0_CSR(DATA0_CSR)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_cmd    (start_cmd),
        .pbuf_words   (pbuf_words),
        .resume_req   (resume_req),
        .busy         (busy),
        .except_abort (except_abort),
        .instr_valid  (instr_valid),
        .instr_ready  (instr_ready),
        .instr_data   (instr_data),
        .core_ebreak  (core_ebreak),
        .core_except  (core_except),
        .core_resume  (core_resume)
    );

    // R14
    valid_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        instr_valid |-> busy);

    // R10
    unsup_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !dec_ok && !busy && cmderr == 3'd0) |=> (!busy && cmderr == 3'd2));
endmodule

// File: tb/dbg_abscmd_seq_tb.sv
module dbg_abscmd_seq_tb_top;
    localparam int          PBN   = 2;
    localparam logic [11:0] CSR_D = 12'hbf0;
    localparam logic [31:0] EBRK  = 32'h0010_0073;

    logic clk = 1'b0;
    logic rst;
    logic cmd_wr, data0_access, pbuf_access, auto_data0, resume_req;
    logic [31:0] cmd_word;
    logic [0:0] pbuf_idx;
    logic [PBN-1:0] auto_pbuf;
    logic [32*PBN-1:0] pbuf_words;
    logic [2:0] cmderr_clr;
    logic busy, instr_valid, instr_ready, core_ebreak, core_except, core_resume;
    logic [2:0] cmderr;
    logic [31:0] instr_data;

    always #4 clk = ~clk;

    dbg_abscmd_seq #(.PB_WORDS(PBN), .DATA0_CSR(CSR_D)) dut_i (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .data0_access(data0_access), .pbuf_access(pbuf_access), .pbuf_idx(pbuf_idx),
        .auto_data0(auto_data0), .auto_pbuf(auto_pbuf), .pbuf_words(pbuf_words),
        .cmderr_clr(cmderr_clr), .resume_req(resume_req), .busy(busy), .cmderr(cmderr),
        .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_data(instr_data),
        .core_ebreak(core_ebreak), .core_except(core_except), .core_resume(core_resume)
    );

    int total = 0;
    int fails = 0;
    logic [31:0] got [16];
    int got_n;
    logic [31:0] expv [16];
    int exp_n;

    // {command word, expected cmderr}
    localparam logic [34:0] VEC [10] = '{
        {32'h0022_1005, 3'd0},   // read x5
        {32'h0023_101f, 3'd0},   // write x31
        {32'h0022_1000, 3'd0},   // read x0
        {32'h0004_0000, 3'd0},   // postexec only
        {32'h0027_100a, 3'd0},   // write x10 then buffer
        {32'h0222_1005, 3'd2},   // memory access type
        {32'h0022_1020, 3'd2},   // regno past GPRs
        {32'h0032_1005, 3'd2},   // size not 32
        {32'h0000_1234, 3'd0},   // nothing to do
        {32'h0026_1011, 3'd0}    // read x17 then buffer
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit cmd_ok(input logic [31:0] c);
        if (c[31:24] != 8'h00) return 1'b0;
        if (c[17] && (c[22:20] != 3'd2 || c[15:0] < 16'h1000 || c[15:0] > 16'h101f)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic build_exp(input logic [31:0] c);
        exp_n = 0;
        if (!cmd_ok(c)) return;
        if (c[17]) begin
            if (c[16]) expv[exp_n] = {CSR_D, 5'd0, 3'b010, c[4:0], 7'b1110011};
            else       expv[exp_n] = {CSR_D, c[4:0], 3'b001, 5'd0, 7'b1110011};
            exp_n++;
            expv[exp_n] = EBRK; exp_n++;
        end
        if (c[18]) begin
            for (int i = 0; i < PBN; i++) begin
                expv[exp_n] = pbuf_words[32*i +: 32]; exp_n++;
            end
            expv[exp_n] = EBRK; exp_n++;
        end
    endtask

    // Acts as the core; called at a negedge, returns at a negedge once idle.
    task automatic serve(input int except_at);
        bit brk_next = 0;
        bit exc_next = 0;
        got_n = 0;
        instr_ready = 1'b1;
        for (int cyc = 0; cyc < 60; cyc++) begin
            core_ebreak = brk_next;
            core_except = exc_next;
            if (brk_next) check(busy == 1'b1, "R3 busy until ebreak", 32'(busy), 32'd1);
            brk_next = 0;
            exc_next = 0;
            if (!instr_valid && !busy && !core_ebreak && !core_except) break;
            if (instr_valid && instr_ready && !core_except) begin
                if (got_n < 16) got[got_n] = instr_data;
                if (got_n == except_at) exc_next = 1;
                else if (instr_data == EBRK) brk_next = 1;
                got_n++;
            end else if (instr_valid && core_except) begin
                if (got_n < 16) got[got_n] = instr_data;
                got_n++;
            end
            @(negedge clk);
        end
        core_ebreak = 1'b0;
        core_except = 1'b0;
    endtask

    task automatic compare_seq(input string req);
        check(got_n == exp_n, req, 32'(got_n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++)
            check(got[i] == expv[i], req, got[i], expv[i]);
    endtask

    task automatic send_cmd(input logic [31:0] c);
        cmd_wr = 1'b1; cmd_word = c;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic clear_err();
        cmderr_clr = 3'b111;
        @(negedge clk);
        cmderr_clr = 3'b000;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_wr = 0; cmd_word = 0; data0_access = 0; pbuf_access = 0;
        pbuf_idx = 0; auto_data0 = 0; auto_pbuf = 0; cmderr_clr = 0; resume_req = 0;
        instr_ready = 1'b1; core_ebreak = 0; core_except = 0;
        pbuf_words = {32'h00a0_0093, 32'h0000_0013};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R14 reset state
        check(busy == 0, "R14 busy", 32'(busy), 0);
        check(cmderr == 0, "R14 cmderr", 32'(cmderr), 0);
        check(instr_valid == 0, "R14 instr_valid", 32'(instr_valid), 0);

        // Table walk: R1 R2 R3 R4 R5 R10
        for (int v = 0; v < 10; v++) begin
            build_exp(VEC[v][34:3]);
            send_cmd(VEC[v][34:3]);
            serve(-1);
            compare_seq("R1/R2/R4/R5 sequence");
            check(cmderr == VEC[v][2:0], "R10 cmderr", 32'(cmderr), 32'(VEC[v][2:0]));
            if (cmderr != 0) clear_err();
        end

        // R13 stall holds the word
        instr_ready = 1'b0;
        send_cmd(32'h0022_1005);
        repeat (3) @(negedge clk);
        check(instr_valid == 1, "R13 valid held", 32'(instr_valid), 1);
        check(instr_data == {CSR_D, 5'd5, 3'b001, 5'd0, 7'b1110011}, "R13 data held",
              instr_data, {CSR_D, 5'd5, 3'b001, 5'd0, 7'b1110011});
        build_exp(32'h0022_1005);
        serve(-1);
        compare_seq("R13 after stall");

        // R9 command while busy
        instr_ready = 1'b0;
        send_cmd(32'h0004_0000);
        send_cmd(32'h0022_1003);
        check(cmderr == 3'd1, "R9 busy error", 32'(cmderr), 1);
        build_exp(32'h0004_0000);
        serve(-1);
        compare_seq("R9 running sequence unaffected");

        // R11 sticky and blocking
        send_cmd(32'h0022_1005);
        check(busy == 0 && instr_valid == 0, "R11 blocked start", 32'(busy), 0);
        cmderr_clr = 3'b010; @(negedge clk); cmderr_clr = 3'b000;
        check(cmderr == 3'd1, "R11 partial clear", 32'(cmderr), 1);
        cmderr_clr = 3'b001; @(negedge clk); cmderr_clr = 3'b000;
        check(cmderr == 3'd0, "R11 clear", 32'(cmderr), 0);

        // R6 data0 auto trigger
        send_cmd(32'h0022_1005);
        serve(-1);
        data0_access = 1; @(negedge clk); data0_access = 0;
        check(busy == 0, "R6 auto off ignored", 32'(busy), 0);
        auto_data0 = 1;
        data0_access = 1; @(negedge clk); data0_access = 0;
        build_exp(32'h0022_1005);
        serve(-1);
        compare_seq("R6 auto re-issue");
        auto_data0 = 0;

        // R7 Program Buffer auto trigger
        auto_pbuf = 2'b10;
        pbuf_access = 1; pbuf_idx = 0; @(negedge clk); pbuf_access = 0;
        check(busy == 0, "R7 disabled word ignored", 32'(busy), 0);
        pbuf_access = 1; pbuf_idx = 1; @(negedge clk); pbuf_access = 0;
        serve(-1);
        compare_seq("R7 enabled word re-issue");
        auto_pbuf = 0;

        // R11 auto blocked by error
        send_cmd(32'h0222_1005);
        auto_data0 = 1;
        data0_access = 1; @(negedge clk); data0_access = 0;
        check(busy == 0 && cmderr == 3'd2, "R11 auto blocked", 32'(cmderr), 2);
        clear_err();

        // R9 auto trigger while busy
        instr_ready = 1'b0;
        send_cmd(32'h0022_1005);
        data0_access = 1; @(negedge clk); data0_access = 0;
        check(cmderr == 3'd1, "R9 auto while busy", 32'(cmderr), 1);
        serve(-1);
        compare_seq("R9 auto collision sequence");
        clear_err();
        auto_data0 = 0;

        // R8 exception mid-buffer
        send_cmd(32'h0004_0000);
        serve(0);
        check(cmderr == 3'd3, "R8 exception code", 32'(cmderr), 3);
        check(busy == 0, "R8 stopped", 32'(busy), 0);
        for (int i = 0; i < got_n && i < 16; i++)
            check(got[i] != EBRK, "R8 no ebreak", got[i], 0);
        clear_err();

        // R12 resume
        resume_req = 1; @(negedge clk); resume_req = 0;
        check(core_resume == 1, "R12 resume idle", 32'(core_resume), 1);
        @(negedge clk);
        check(core_resume == 0, "R12 single pulse", 32'(core_resume), 0);
        instr_ready = 1'b0;
        send_cmd(32'h0022_1005);
        resume_req = 1; @(negedge clk); resume_req = 0;
        check(core_resume == 0, "R12 resume busy ignored", 32'(core_resume), 0);
        serve(-1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule